// File: doc/BRIEF.md
# Trace-Aligned Breakpoint Request Controller

This block is the control core of an on-chip debug unit. A trigger, either from the comparator-driven state sequencer or from a software-forced trigger, ends a wait phase. The block then controls when trace lines are written and whether a breakpoint request is raised. A two-bit alignment field decides where recording sits relative to the trigger:

- up to the trigger,
- starting at the trigger until the buffer is full, or
- a fixed number of lines after the trigger.

An immediate-break bit ends recording on the trigger itself. Comparator matching and the trace memory are outside the block: it only qualifies the store strobe into a write enable.

A break request is a single-cycle pulse routed to one of two targets: background-debug entry or software interrupt. The choice depends on a routing bit and on the background-debug status flags. Software sets the arm bit with `arm_set` and can abort with `arm_clr`. When a session finishes, the arm bit drops by itself and `sess_done` pulses for one cycle.

Top module: `dbg_brk_ctrl`

## Requirements
- R1: With `aln_mode`=2'b00 and `imm_brk`=0, every `store_stb` raises `trace_we` while armed and waiting, including the trigger cycle. Recording stops at the trigger, and `sess_done` and the break pulse appear in the cycle after the trigger cycle.
- R2: With `aln_mode`=2'b01 and `imm_brk`=0, no line is written before the trigger. After the trigger, exactly DEPTH (default 64) strobes are written. `sess_done` and the break pulse appear in the cycle after the DEPTH-th written line.
- R3: With `aln_mode`=2'b10 and `imm_brk`=0, exactly POST_LINES (default 32) strobes are written after the trigger. The session completes in the cycle after the last of them.
- R4: With `imm_brk`=1 and `aln_mode` 2'b00, 2'b01 or 2'b10, the session completes on the trigger, with `sess_done` in the next cycle. No line is written after the trigger, and a break is raised only if `brk_en`=1.
- R5: With `aln_mode`=2'b11, no line is written, neither trigger has any effect, and the unit stays armed.
- R6: A forced trigger acts like a comparator trigger while armed. With `trace_sel`=1 and begin or mid alignment, its break waits for the end of the recording. With `trace_sel`=0, the session completes and the break comes in the next cycle.
- R7: While disarmed, `force_trig` raises a break pulse in the next cycle, with no `sess_done` and no change of `armed`. `cmp_trig` does nothing while disarmed.
- R8: When `bdm_active`=1 at the completing edge, neither break output pulses. When `bdm_trace`=1 at that edge, `brk_bdm` is suppressed.
- R9: With `brk_en`=0, no break is requested. Otherwise `route_bdm`=0 selects `brk_swi` and `route_bdm`=1 selects `brk_bdm`. The two outputs are never high together, so a break that meets a software-interrupt instruction is delivered to background debug only.
- R10: Once post-trigger recording is running, further comparator or forced triggers are ignored, including one in the completion cycle. The session keeps its length and yields exactly one break.
- R11: Completion clears `armed` in the cycle `sess_done` is high. `sess_done` and the break pulse last exactly one cycle and coincide.
- R12: After reset all outputs are low. `arm_set` raises `armed` in the next cycle, and `arm_clr` drops it without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_set | input | 1 | Set the arm bit |
| arm_clr | input | 1 | Clear the arm bit, abort session |
| aln_mode | input | 2 | Trace alignment: 00 end, 01 begin, 10 mid, 11 reserved |
| imm_brk | input | 1 | End recording on the trigger itself |
| brk_en | input | 1 | Breakpoint enable |
| route_bdm | input | 1 | 1: break to background debug, 0: to software interrupt |
| trace_sel | input | 1 | A trace session is selected |
| cmp_trig | input | 1 | Comparator sequencer trigger |
| force_trig | input | 1 | Software-forced trigger |
| store_stb | input | 1 | Trace line ready to store |
| bdm_active | input | 1 | Background-debug firmware running |
| bdm_trace | input | 1 | Background-debug trace command running |
| trace_we | output | 1 | Trace buffer write enable |
| armed | output | 1 | Arm bit |
| sess_done | output | 1 | One-cycle session-complete pulse |
| brk_bdm | output | 1 | Break request to background debug |
| brk_swi | output | 1 | Break request to software interrupt |

## Verification
A line counter that is off by one shows up at the ports in two ways: the write-enable count differs from DEPTH or POST_LINES, and `sess_done` appears a cycle early or late against the strobe count. Both are measured in every session. A sequencer that leaves the post-trigger state on a late trigger shows as a short session and a second break pulse within one cycle of that trigger. A routing fault shows as the wrong output, or both outputs, pulsing in the cycle after completion.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;

  typedef enum logic [1:0] {
    ALN_END   = 2'b00,
    ALN_BEGIN = 2'b01,
    ALN_MID   = 2'b10,
    ALN_RSVD  = 2'b11
  } aln_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_POST = 2'd2
  } sq_e;

endpackage

// File: rtl/dbg_line_cnt.sv
module dbg_line_cnt #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] target,
  output logic          last
);

  logic [CW-1:0] count_q;
  logic [CW-1:0] count_d;
  logic          count_en;

  always_comb begin
    count_en = clr | inc;
    count_d  = clr ? '0 : count_q + CW'(1);
    last     = inc && !clr && (count_q == target - CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  // R3: the line count never runs past the buffer depth
  a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH));

endmodule

// File: rtl/dbg_sess_fsm.sv
module dbg_sess_fsm
  import dbg_brk_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int POST_LINES = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_set,
  input  logic          arm_clr,
  input  aln_e          aln,
  input  logic          imm_brk,
  input  logic          trace_sel,
  input  logic          cmp_trig,
  input  logic          force_trig,
  input  logic          store_stb,
  input  logic          cnt_last,
  output logic          rec,
  output logic          cnt_inc,
  output logic          cnt_clr,
  output logic [CW-1:0] target,
  output logic          fire,
  output logic          done_now,
  output logic          armed
);

  sq_e  state_q, state_d;
  logic rsvd;
  logic trig_any;
  logic end_at_trig;

  always_comb begin
    rsvd        = (aln == ALN_RSVD);
    trig_any    = (cmp_trig | force_trig) & ~rsvd;
    end_at_trig = ~trace_sel | imm_brk | (aln == ALN_END);
    target      = (aln == ALN_MID) ? CW'(POST_LINES) : CW'(DEPTH);
    state_d     = state_q;
    rec         = 1'b0;
    cnt_inc     = 1'b0;
    cnt_clr     = (state_q != SQ_POST);
    fire        = 1'b0;
    done_now    = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        fire = force_trig & ~rsvd;
        if (arm_set) state_d = SQ_WAIT;
      end
      SQ_WAIT: begin
        rec = trace_sel & (aln == ALN_END);
        if (arm_clr) begin
          state_d = SQ_IDLE;
        end else if (trig_any) begin
          if (end_at_trig) begin
            done_now = 1'b1;
            fire     = 1'b1;
            state_d  = SQ_IDLE;
          end else begin
            state_d  = SQ_POST;
          end
        end
      end
      SQ_POST: begin
        rec     = 1'b1;
        cnt_inc = store_stb;
        if (cnt_last) begin
          done_now = 1'b1;
          fire     = 1'b1;
          state_d  = SQ_IDLE;
        end else if (arm_clr) begin
          state_d  = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q != SQ_IDLE);

  // R10: late triggers cannot pull the sequencer out of post-trigger recording
  a_r10_post_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_POST && !cnt_last && !arm_clr) |=> (state_q == SQ_POST));

  // R11: a completing session always returns to the disarmed state
  a_r11_done_leaves: assert property (@(posedge clk) disable iff (!rst_n)
    done_now |=> (state_q == SQ_IDLE));

endmodule

// File: rtl/dbg_brk_route.sv
module dbg_brk_route (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic done_now,
  input  logic brk_en,
  input  logic route_bdm,
  input  logic bdm_active,
  input  logic bdm_trace,
  output logic brk_bdm,
  output logic brk_swi,
  output logic sess_done
);

  logic brk_ok;
  logic bdm_d, swi_d;

  always_comb begin
    brk_ok = fire & brk_en & ~bdm_active;
    bdm_d  = brk_ok & route_bdm & ~bdm_trace;
    swi_d  = brk_ok & ~route_bdm;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_bdm   <= 1'b0;
      brk_swi   <= 1'b0;
      sess_done <= 1'b0;
    end else begin
      brk_bdm   <= bdm_d;
      brk_swi   <= swi_d;
      sess_done <= done_now;
    end
  end

  // R8: background-debug activity blocks every break request
  a_r8_bdm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    bdm_active |=> (!brk_bdm && !brk_swi));

  // R9: a break never goes to both targets
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    !(brk_bdm && brk_swi));

endmodule

// File: rtl/dbg_brk_ctrl.sv
module dbg_brk_ctrl
  import dbg_brk_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int POST_LINES = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_set,
  input  logic       arm_clr,
  input  logic [1:0] aln_mode,
  input  logic       imm_brk,
  input  logic       brk_en,
  input  logic       route_bdm,
  input  logic       trace_sel,
  input  logic       cmp_trig,
  input  logic       force_trig,
  input  logic       store_stb,
  input  logic       bdm_active,
  input  logic       bdm_trace,
  output logic       trace_we,
  output logic       armed,
  output logic       sess_done,
  output logic       brk_bdm,
  output logic       brk_swi
);

  localparam int CW = $clog2(DEPTH + 1);

  logic          rec, cnt_inc, cnt_clr, cnt_last;
  logic          fire, done_now;
  logic [CW-1:0] target;

  dbg_sess_fsm #(.DEPTH(DEPTH), .POST_LINES(POST_LINES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .arm_set    (arm_set),
    .arm_clr    (arm_clr),
    .aln        (aln_e'(aln_mode)),
    .imm_brk    (imm_brk),
    .trace_sel  (trace_sel),
    .cmp_trig   (cmp_trig),
    .force_trig (force_trig),
    .store_stb  (store_stb),
    .cnt_last   (cnt_last),
    .rec        (rec),
    .cnt_inc    (cnt_inc),
    .cnt_clr    (cnt_clr),
    .target     (target),
    .fire       (fire),
    .done_now   (done_now),
    .armed      (armed)
  );

  dbg_line_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (cnt_clr),
    .inc    (cnt_inc),
    .target (target),
    .last   (cnt_last)
  );

  dbg_brk_route u_route (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .done_now   (done_now),
    .brk_en     (brk_en),
    .route_bdm  (route_bdm),
    .bdm_active (bdm_active),
    .bdm_trace  (bdm_trace),
    .brk_bdm    (brk_bdm),
    .brk_swi    (brk_swi),
    .sess_done  (sess_done)
  );

  assign trace_we = store_stb & rec;

  // R11: completion leaves the unit disarmed while the done pulse is high
  a_r11_done_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    sess_done |-> !armed);

  // R11: the done pulse lasts a single cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    sess_done |=> !sess_done);

  // R5: the reserved alignment never writes the trace buffer
  a_r5_rsvd_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (aln_mode == 2'b11 && $past(aln_mode) == 2'b11 && !$past(armed)) |-> !trace_we);

endmodule

// File: tb/sim_dbg_brk_ctrl.sv
`timescale 1ns/1ps
module sim_dbg_brk_ctrl;

  logic clk = 1'b0;
  logic rst_n;
  logic arm_set, arm_clr, imm_brk, brk_en, route_bdm, trace_sel;
  logic cmp_trig, force_trig, store_stb, bdm_active, bdm_trace;
  logic [1:0] aln_mode;
  logic trace_we, armed, sess_done, brk_bdm, brk_swi;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  dbg_brk_ctrl #(.DEPTH(64), .POST_LINES(32)) u0 (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .arm_clr(arm_clr),
    .aln_mode(aln_mode), .imm_brk(imm_brk), .brk_en(brk_en),
    .route_bdm(route_bdm), .trace_sel(trace_sel), .cmp_trig(cmp_trig),
    .force_trig(force_trig), .store_stb(store_stb), .bdm_active(bdm_active),
    .bdm_trace(bdm_trace), .trace_we(trace_we), .armed(armed),
    .sess_done(sess_done), .brk_bdm(brk_bdm), .brk_swi(brk_swi)
  );

  typedef struct packed {
    logic [1:0] aln;
    logic       imm, en, rt, tsel, frc, bdma, bdmt;
    logic [7:0] retrig;
    logic [7:0] exp_wr;
    logic       exp_done;
    logic [7:0] exp_lat;
    logic [1:0] exp_swi;
    logic [1:0] exp_bdm;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'b00,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0 ,8'd3 ,1'b1,8'd1 ,2'd1,2'd0}, // R1
    '{2'b01,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,8'd0 ,8'd64,1'b1,8'd65,2'd0,2'd1}, // R2
    '{2'b10,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'd5 ,8'd32,1'b1,8'd33,2'd1,2'd0}, // R3 R10
    '{2'b10,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0 ,8'd32,1'b1,8'd33,2'd0,2'd0}, // R9
    '{2'b01,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0 ,8'd0 ,1'b1,8'd1 ,2'd1,2'd0}, // R4
    '{2'b00,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,8'd0 ,8'd3 ,1'b1,8'd1 ,2'd0,2'd0}, // R4
    '{2'b11,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,8'd0 ,8'd0 ,1'b0,8'd0 ,2'd0,2'd0}, // R5
    '{2'b10,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'd7 ,8'd32,1'b1,8'd33,2'd0,2'd1}, // R6 R10
    '{2'b10,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'd0 ,8'd0 ,1'b1,8'd1 ,2'd1,2'd0}, // R6
    '{2'b01,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,8'd0 ,8'd64,1'b1,8'd65,2'd0,2'd0}, // R8
    '{2'b01,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b1,8'd64,8'd64,1'b1,8'd65,2'd0,2'd0}, // R8 R10
    '{2'b01,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,8'd64,8'd64,1'b1,8'd65,2'd0,2'd1}  // R10
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    arm_set = 0; arm_clr = 0; cmp_trig = 0; force_trig = 0; store_stb = 0;
  endtask

  task automatic run_vec(input vec_t v, input string req);
    int wr = 0, swi = 0, bdm = 0, lat = 0, both = 0, brk_at = -1;
    bit done_seen = 0;
    @(negedge clk);
    idle_inputs();
    aln_mode = v.aln; imm_brk = v.imm; brk_en = v.en; route_bdm = v.rt;
    trace_sel = v.tsel; bdm_active = v.bdma; bdm_trace = v.bdmt;
    arm_set = 1;
    @(negedge clk); arm_set = 0;
    for (int k = -3; k <= 80; k++) begin
      if (k > -3) @(negedge clk);
      idle_inputs();
      store_stb = (k != 0);
      if (k == 0 || (v.retrig != 0 && k == int'(v.retrig))) begin
        if (v.frc) force_trig = 1; else cmp_trig = 1;
      end
      #1;
      wr  += int'(trace_we);
      swi += int'(brk_swi);
      bdm += int'(brk_bdm);
      if (brk_swi && brk_bdm) both++;
      if ((brk_swi || brk_bdm) && brk_at < 0) brk_at = k;
      if (sess_done && !done_seen) begin done_seen = 1; lat = k; end
    end
    check(wr == int'(v.exp_wr), req, "trace writes", wr, int'(v.exp_wr));
    check(done_seen == v.exp_done, req, "session done", int'(done_seen), int'(v.exp_done));
    if (v.exp_done)
      check(lat == int'(v.exp_lat), req, "done latency", lat, int'(v.exp_lat));
    check(swi == int'(v.exp_swi), req, "swi pulses", swi, int'(v.exp_swi));
    check(bdm == int'(v.exp_bdm), req, "bdm pulses", bdm, int'(v.exp_bdm));
    check(both == 0, "R9", "both targets", both, 0);
    if (brk_at >= 0)
      check(brk_at == lat, "R11", "break vs done cycle", brk_at, lat);
    check(armed == !v.exp_done, req, "armed after", int'(armed), int'(!v.exp_done));
    @(negedge clk); idle_inputs(); arm_clr = 1;
    @(negedge clk); arm_clr = 0;
    bdm_active = 0; bdm_trace = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0;
    idle_inputs();
    aln_mode = 2'b00; imm_brk = 0; brk_en = 0; route_bdm = 0; trace_sel = 0;
    bdm_active = 0; bdm_trace = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R12 reset state
    check({trace_we, armed, sess_done, brk_bdm, brk_swi} == 5'b0, "R12", "reset outputs",
          int'({trace_we, armed, sess_done, brk_bdm, brk_swi}), 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("vec%0d", i);
      run_vec(VEC[i], tag);
    end

    // R7: forced trigger while disarmed
    @(negedge clk);
    idle_inputs(); aln_mode = 2'b00; brk_en = 1; route_bdm = 0; trace_sel = 1;
    force_trig = 1;
    @(negedge clk); force_trig = 0; #1;
    check(brk_swi == 1, "R7", "disarmed force swi", int'(brk_swi), 1);
    check(sess_done == 0, "R7", "disarmed force done", int'(sess_done), 0);
    check(armed == 0, "R7", "disarmed force armed", int'(armed), 0);
    cmp_trig = 1;
    @(negedge clk); cmp_trig = 0; #1;
    check(brk_swi == 0 && brk_bdm == 0, "R7", "disarmed cmp break",
          int'(brk_swi | brk_bdm), 0);

    // R12: arm and abort
    arm_set = 1;
    @(negedge clk); arm_set = 0; #1;
    check(armed == 1, "R12", "armed after set", int'(armed), 1);
    arm_clr = 1;
    @(negedge clk); arm_clr = 0; #1;
    check(armed == 0, "R12", "armed after clear", int'(armed), 0);
    cmp_trig = 1;
    @(negedge clk); cmp_trig = 0; #1;
    check(brk_swi == 0 && sess_done == 0, "R12", "trigger after abort",
          int'(brk_swi | sess_done), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule